// File: doc/BRIEF.md
# Video RAM Slot Arbiter with Buffered Read-Modify-Write

This block shares one video DRAM with a multiplexed 8-bit address bus between a display fetch engine and a CPU port. Memory time is cut into fixed four-cycle slots. A set number of display slots is followed by one CPU slot, and the pattern repeats. Each display slot reads two neighbouring bytes from both data lanes and hands them to the pixel shift register with a load pulse. Lane A carries planes I/II and lane B carries planes III/IV. Each CPU slot carries a CPU read, one pass of a buffered write, or nothing. The strobes follow read timing in every CPU slot, whether or not the CPU asked for anything.

A CPU write is held in a one-byte buffer and is performed later as read-modify-write. The old byte is read, combined with the CPU byte through a 3-bit logical operation, and written back under per-plane enables. In the 16-colour mode a write takes two CPU slots, one per plane bank. The CPU wait output follows these rules: reads always stall until their data has been fetched in a CPU slot; writes stall only while the buffer is occupied; in compatibility mode, writes also stall once a quota of writes has been used inside one display (non-blanking) period.

Top module: `vram_arb_top`

## Requirements
- R1: While `rstN` is low, `vRowStb`, `vColStb`, `vOe`, both write strobes, `pixLoad` and `cpuWait` (with no request) are low. The first row strobe after release carries row 0 on `vAddr`.
- R2: Every slot lasts 4 cycles. `vRowStb` is high in cycles 1-3 and `vColStb` is high in cycles 2-3. Slots run as `DISP_SLOTS` display slots and then one CPU slot, and the strobes run in every slot.
- R3: A display slot puts the row of address N on `vAddr`, then column N, then column N+1. N is even, starts at 0 after reset and advances by 2 in each display slot.
- R4: `pixLoad` is a one-cycle pulse in cycle 4 of every display slot. At that time `pixA`/`pixB` hold {byte N+1, byte N} of lanes A/B.
- R5: A buffered write reads the old byte in cycle 2 of a CPU slot. In cycle 3 it re-issues the column with `vOe` low and drives `vWrA`/`vWrB` = op(old, data), with op 1 = XOR, 2 = OR, 3 = old AND NOT data, and 0 and 4-7 = replace.
- R6: The write strobe of lane A in bank b follows plane enable bit b, and that of lane B follows bit 2+b. In 16-colour mode a write makes bank 0 and then bank 1 passes in consecutive CPU slots. Otherwise it makes one bank 0 pass.
- R7: In native mode a write into an empty buffer is accepted with no wait.
- R8: A write that arrives while the buffer is occupied waits until the buffer drains. Writes reach the DRAM in acceptance order.
- R9: In compatibility mode with `blank` low, the third and later writes of a display period wait until `blank` rises. Blanking clears the quota.
- R10: A CPU read always raises `cpuWait` at first. Wait drops once the read has been fetched in a CPU slot, and `cpuRdData` = {lane B, lane A} at that address.
- R11: A CPU slot with no work keeps read timing: `vOe` is high in cycles 2-3 and no write strobe is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| modeCompat | input | 1 | 1 = compatibility mode with write quota |
| mode16 | input | 1 | 1 = 16-colour mode (two-pass writes), sampled when a write is accepted |
| blank | input | 1 | 1 = flyback period |
| cpuReq | input | 1 | CPU access request, held until wait is low at a clock edge |
| cpuWe | input | 1 | 1 = write, 0 = read |
| cpuAddr | input | 2*MUX_W | CPU byte address, row in the upper half |
| cpuWrData | input | DATA_W | CPU write byte |
| cpuOp | input | 3 | Logical operation for the write |
| cpuPlaneEn | input | 4 | Plane enables, bit 0 = plane I ... bit 3 = plane IV |
| cpuWait | output | 1 | CPU stall |
| cpuRdData | output | 2*DATA_W | Read data {lane B, lane A} |
| vRowStb | output | 1 | Row strobe, active high |
| vColStb | output | 1 | Column strobe, active high |
| vOe | output | 1 | Output enable, active high |
| vWeA | output | 1 | Write strobe for lane A |
| vWeB | output | 1 | Write strobe for lane B |
| vBank | output | 1 | Plane bank of the current write pass |
| vAddr | output | MUX_W | Multiplexed row/column address |
| vWrA | output | DATA_W | Write data for lane A |
| vWrB | output | DATA_W | Write data for lane B |
| vRdA | input | DATA_W | Read data from lane A |
| vRdB | input | DATA_W | Read data from lane B |
| pixA | output | 2*DATA_W | Lane A bytes for the shifter |
| pixB | output | 2*DATA_W | Lane B bytes for the shifter |
| pixLoad | output | 1 | Shift register load pulse |

## Verification
The bench builds the block with `DISP_SLOTS` = 2 instead of the default 1. This leaves two display slots between CPU slots, so a write or read that just misses a CPU slot stalls for a visibly longer, slot-aligned stretch. A wrong slot count or a wrong display address step also shows up as a broken N, N+1 sequence. `FREE_WR` stays at 2, so the third write in a display period is the one that must stall in compatibility mode. The byte and address widths stay at 8 and 16, so every row, column and operation result is computed directly from the bench's own address-to-data function.

// File: rtl/vram_arb_pkg.sv
package vram_arb_pkg;

  // address source for the multiplexed bus
  typedef enum logic [1:0] {SRC_DISP, SRC_CPU, SRC_BUF} addrSrc_e;
  // which half of the source goes out
  typedef enum logic [1:0] {AS_NONE, AS_ROW, AS_COL, AS_NEXT} addrSel_e;
  // work carried by a CPU slot
  typedef enum logic [1:0] {JOB_IDLE, JOB_READ, JOB_WRITE} job_e;

  localparam logic [2:0] OP_XOR    = 3'd1;
  localparam logic [2:0] OP_OR     = 3'd2;
  localparam logic [2:0] OP_ANDNOT = 3'd3;

  // strobes from control to datapath
  typedef struct packed {
    logic     rowStb;
    logic     colStb;
    logic     oe;
    logic     we;
    logic     bank;
    addrSrc_e src;
    addrSel_e sel;
    logic     capOld;
    logic     capLo;
    logic     capHi;
    logic     bufLoad;
  } ctlStb_t;

endpackage

// File: rtl/vramCtrl.sv
module vramCtrl
  import vram_arb_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int DISP_SLOTS = 1,
  parameter int FREE_WR    = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              modeCompat,
  input  logic              mode16,
  input  logic              blank,
  input  logic              cpuReq,
  input  logic              cpuWe,
  output ctlStb_t           stb,
  output logic [ADDR_W-1:0] dispAddr,
  output logic              cpuWait
);
  localparam int SLOT_W = (DISP_SLOTS < 1) ? 1 : $clog2(DISP_SLOTS + 1);
  localparam int CNT_W  = $clog2(FREE_WR + 1);

  logic              live;
  logic [1:0]        phase;
  logic [SLOT_W-1:0] slotIdx;
  job_e              jobQ, jobNow;
  logic              bufFull, bufM16, pass, rdDone;
  logic [CNT_W-1:0]  wrCnt;
  logic              cpuSlot, writeLimit, bufLoad, readHs;

  assign cpuSlot    = (slotIdx == SLOT_W'(DISP_SLOTS));
  assign writeLimit = modeCompat & ~blank & (wrCnt == CNT_W'(FREE_WR));
  assign bufLoad    = cpuReq & cpuWe & ~bufFull & ~writeLimit;
  assign readHs     = cpuReq & ~cpuWe & rdDone;
  assign cpuWait    = cpuReq & (cpuWe ? (bufFull | writeLimit) : ~rdDone);

  // slot work is fixed in the first cycle of the slot
  always_comb begin
    jobNow = jobQ;
    if (phase == 2'd0) begin
      if (!cpuSlot)                   jobNow = JOB_IDLE;
      else if (bufFull)               jobNow = JOB_WRITE;
      else if (cpuReq && !cpuWe && !rdDone) jobNow = JOB_READ;
      else                            jobNow = JOB_IDLE;
    end
  end

  always_comb begin
    stb         = '0;
    stb.src     = SRC_DISP;
    stb.sel     = AS_NONE;
    stb.bufLoad = bufLoad;
    if (live) begin
      stb.rowStb = (phase != 2'd3);
      stb.colStb = (phase == 2'd1) || (phase == 2'd2);
      if (!cpuSlot) begin
        stb.src   = SRC_DISP;
        stb.oe    = stb.colStb;
        stb.capLo = (phase == 2'd1);
        stb.capHi = (phase == 2'd2);
        case (phase)
          2'd0:    stb.sel = AS_ROW;
          2'd1:    stb.sel = AS_COL;
          2'd2:    stb.sel = AS_NEXT;
          default: stb.sel = AS_NONE;
        endcase
      end else begin
        stb.src    = (jobNow == JOB_WRITE) ? SRC_BUF : SRC_CPU;
        stb.oe     = (phase == 2'd1) || ((phase == 2'd2) && (jobNow != JOB_WRITE));
        stb.capOld = (phase == 2'd1) && (jobNow != JOB_IDLE);
        stb.we     = (phase == 2'd2) && (jobNow == JOB_WRITE);
        stb.bank   = (jobNow == JOB_WRITE) && pass;
        case (phase)
          2'd0:        stb.sel = AS_ROW;
          2'd1, 2'd2:  stb.sel = AS_COL;
          default:     stb.sel = AS_NONE;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      live     <= 1'b0;
      phase    <= 2'd0;
      slotIdx  <= '0;
      jobQ     <= JOB_IDLE;
      dispAddr <= '0;
    end else begin
      live <= 1'b1;
      jobQ <= jobNow;
      if (live) begin
        phase <= phase + 2'd1;
        if (phase == 2'd3) begin
          slotIdx <= cpuSlot ? '0 : slotIdx + SLOT_W'(1);
          if (!cpuSlot) dispAddr <= dispAddr + ADDR_W'(2);
        end
      end
    end
  end

  // write buffer occupancy and pass tracking
  always_ff @(posedge clk) begin
    if (!rstN) begin
      bufFull <= 1'b0;
      bufM16  <= 1'b0;
      pass    <= 1'b0;
    end else if (live && cpuSlot && phase == 2'd2 && jobNow == JOB_WRITE) begin
      if (bufM16 && !pass) begin
        pass <= 1'b1;
      end else begin
        pass    <= 1'b0;
        bufFull <= 1'b0;
      end
    end else if (bufLoad) begin
      bufFull <= 1'b1;
      bufM16  <= mode16;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                                          rdDone <= 1'b0;
    else if (readHs)                                    rdDone <= 1'b0;
    else if (live && cpuSlot && phase == 2'd1 && jobNow == JOB_READ) rdDone <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN || blank)                           wrCnt <= '0;
    else if (bufLoad && wrCnt != CNT_W'(FREE_WR)) wrCnt <= wrCnt + CNT_W'(1);
  end

endmodule

// File: rtl/vramDatapath.sv
module vramDatapath
  import vram_arb_pkg::*;
#(
  parameter int MUX_W  = 8,
  parameter int DATA_W = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  ctlStb_t               stb,
  input  logic [2*MUX_W-1:0]    dispAddr,
  input  logic [2*MUX_W-1:0]    cpuAddr,
  input  logic [DATA_W-1:0]     cpuWrData,
  input  logic [2:0]            cpuOp,
  input  logic [3:0]            cpuPlaneEn,
  input  logic [DATA_W-1:0]     vRdA,
  input  logic [DATA_W-1:0]     vRdB,
  output logic [MUX_W-1:0]      vAddr,
  output logic                  vWeA,
  output logic                  vWeB,
  output logic [DATA_W-1:0]     vWrA,
  output logic [DATA_W-1:0]     vWrB,
  output logic [2*DATA_W-1:0]   cpuRdData,
  output logic [2*DATA_W-1:0]   pixA,
  output logic [2*DATA_W-1:0]   pixB,
  output logic                  pixLoad
);
  localparam int ADDR_W = 2 * MUX_W;
  localparam int LANES  = 2;

  logic [ADDR_W-1:0] bufAddr, srcAddr;
  logic [DATA_W-1:0] bufData;
  logic [2:0]        bufOp;
  logic [3:0]        bufEn;
  logic [MUX_W-1:0]  nextCol;

  logic [LANES-1:0][DATA_W-1:0]   rdLane, oldLane, wrLane;
  logic [LANES-1:0][2*DATA_W-1:0] pixLane;
  logic [LANES-1:0]               weLane;

  function automatic logic [DATA_W-1:0] combine(input logic [DATA_W-1:0] oldV,
                                                input logic [DATA_W-1:0] newV,
                                                input logic [2:0] op);
    case (op)
      OP_XOR:    return oldV ^ newV;
      OP_OR:     return oldV | newV;
      OP_ANDNOT: return oldV & ~newV;
      default:   return newV;
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bufAddr <= '0;
      bufData <= '0;
      bufOp   <= '0;
      bufEn   <= '0;
    end else if (stb.bufLoad) begin
      bufAddr <= cpuAddr;
      bufData <= cpuWrData;
      bufOp   <= cpuOp;
      bufEn   <= cpuPlaneEn;
    end
  end

  always_comb begin
    case (stb.src)
      SRC_CPU: srcAddr = cpuAddr;
      SRC_BUF: srcAddr = bufAddr;
      default: srcAddr = dispAddr;
    endcase
  end

  assign nextCol = srcAddr[MUX_W-1:0] + MUX_W'(1);

  always_comb begin
    case (stb.sel)
      AS_ROW:  vAddr = srcAddr[ADDR_W-1:MUX_W];
      AS_COL:  vAddr = srcAddr[MUX_W-1:0];
      AS_NEXT: vAddr = nextCol;
      default: vAddr = '0;
    endcase
  end

  assign rdLane[0] = vRdA;
  assign rdLane[1] = vRdB;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [DATA_W-1:0]   oldQ, loQ;
    logic [2*DATA_W-1:0] pixQ;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        oldQ <= '0;
        loQ  <= '0;
        pixQ <= '0;
      end else begin
        if (stb.capOld) oldQ <= rdLane[g];
        if (stb.capLo)  loQ  <= rdLane[g];
        if (stb.capHi)  pixQ <= {rdLane[g], loQ};
      end
    end

    assign oldLane[g] = oldQ;
    assign pixLane[g] = pixQ;
    assign wrLane[g]  = combine(oldQ, bufData, bufOp);
    // lane g, bank b -> plane enable bit 2*g+b
    assign weLane[g]  = stb.we & bufEn[2*g + (stb.bank ? 1 : 0)];
  end

  always_ff @(posedge clk) begin
    if (!rstN) pixLoad <= 1'b0;
    else       pixLoad <= stb.capHi;
  end

  assign vWrA      = wrLane[0];
  assign vWrB      = wrLane[1];
  assign vWeA      = weLane[0];
  assign vWeB      = weLane[1];
  assign cpuRdData = {oldLane[1], oldLane[0]};
  assign pixA      = pixLane[0];
  assign pixB      = pixLane[1];

endmodule

// File: rtl/vram_arb_top.sv
module vram_arb_top
  import vram_arb_pkg::*;
#(
  parameter int MUX_W      = 8,
  parameter int DATA_W     = 8,
  parameter int DISP_SLOTS = 1,
  parameter int FREE_WR    = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                modeCompat,
  input  logic                mode16,
  input  logic                blank,
  input  logic                cpuReq,
  input  logic                cpuWe,
  input  logic [2*MUX_W-1:0]  cpuAddr,
  input  logic [DATA_W-1:0]   cpuWrData,
  input  logic [2:0]          cpuOp,
  input  logic [3:0]          cpuPlaneEn,
  output logic                cpuWait,
  output logic [2*DATA_W-1:0] cpuRdData,
  output logic                vRowStb,
  output logic                vColStb,
  output logic                vOe,
  output logic                vWeA,
  output logic                vWeB,
  output logic                vBank,
  output logic [MUX_W-1:0]    vAddr,
  output logic [DATA_W-1:0]   vWrA,
  output logic [DATA_W-1:0]   vWrB,
  input  logic [DATA_W-1:0]   vRdA,
  input  logic [DATA_W-1:0]   vRdB,
  output logic [2*DATA_W-1:0] pixA,
  output logic [2*DATA_W-1:0] pixB,
  output logic                pixLoad
);
  localparam int ADDR_W = 2 * MUX_W;

  ctlStb_t           stb;
  logic [ADDR_W-1:0] dispAddr;

  vramCtrl #(.ADDR_W(ADDR_W), .DISP_SLOTS(DISP_SLOTS), .FREE_WR(FREE_WR)) ctrl_i (
    .clk(clk), .rstN(rstN), .modeCompat(modeCompat), .mode16(mode16), .blank(blank),
    .cpuReq(cpuReq), .cpuWe(cpuWe), .stb(stb), .dispAddr(dispAddr), .cpuWait(cpuWait)
  );

  vramDatapath #(.MUX_W(MUX_W), .DATA_W(DATA_W)) dp_i (
    .clk(clk), .rstN(rstN), .stb(stb), .dispAddr(dispAddr), .cpuAddr(cpuAddr),
    .cpuWrData(cpuWrData), .cpuOp(cpuOp), .cpuPlaneEn(cpuPlaneEn),
    .vRdA(vRdA), .vRdB(vRdB), .vAddr(vAddr), .vWeA(vWeA), .vWeB(vWeB),
    .vWrA(vWrA), .vWrB(vWrB), .cpuRdData(cpuRdData), .pixA(pixA), .pixB(pixB),
    .pixLoad(pixLoad)
  );

  assign vRowStb = stb.rowStb;
  assign vColStb = stb.colStb;
  assign vOe     = stb.oe;
  assign vBank   = stb.bank;

endmodule

// File: rtl/vram_arb_chk.sv
module vram_arb_chk (
  input logic clk,
  input logic rstN,
  input logic vRowStb,
  input logic vColStb,
  input logic vOe,
  input logic vWeA,
  input logic vWeB,
  input logic pixLoad
);
  // R2
  col_inside_row_chk: assert property (@(posedge clk) disable iff (!rstN)
    vColStb |-> vRowStb);

  // R2
  row_then_col_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(vRowStb) |=> vColStb);

  // R5
  write_in_col_no_oe_chk: assert property (@(posedge clk) disable iff (!rstN)
    (vWeA || vWeB) |-> (vColStb && !vOe));

  // R4
  load_single_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    pixLoad |=> !pixLoad);

  // R11
  oe_with_col_chk: assert property (@(posedge clk) disable iff (!rstN)
    vOe |-> vColStb);
endmodule

bind vram_arb_top vram_arb_chk chk_i (
  .clk(clk), .rstN(rstN), .vRowStb(vRowStb), .vColStb(vColStb), .vOe(vOe),
  .vWeA(vWeA), .vWeB(vWeB), .pixLoad(pixLoad)
);

// File: tb/vram_arb_top_tb_top.sv
module vram_arb_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 8;
  // {addr, data, op, planeEn, mode16}
  localparam logic [31:0] VEC [NVEC] = '{
    {16'h1234, 8'hA5, 3'd0, 4'b0101, 1'b0},
    {16'h20F0, 8'h3C, 3'd1, 4'b0101, 1'b0},
    {16'h7F01, 8'h81, 3'd2, 4'b0001, 1'b0},
    {16'h0A0A, 8'hF0, 3'd3, 4'b0100, 1'b0},
    {16'hFFFE, 8'h5A, 3'd5, 4'b0101, 1'b0},
    {16'h4321, 8'h0F, 3'd1, 4'b1111, 1'b1},
    {16'h00FF, 8'hC3, 3'd3, 4'b1010, 1'b1},
    {16'h9988, 8'h77, 3'd7, 4'b0000, 1'b1}
  };

  logic clk = 0, rstN = 0;
  logic modeCompat = 0, mode16 = 0, blank = 1, cpuReq = 0, cpuWe = 0;
  logic [15:0] cpuAddr = 0;
  logic [7:0]  cpuWrData = 0;
  logic [2:0]  cpuOp = 0;
  logic [3:0]  cpuPlaneEn = 0;
  logic cpuWait, vRowStb, vColStb, vOe, vWeA, vWeB, vBank, pixLoad;
  logic [15:0] cpuRdData, pixA, pixB;
  logic [7:0]  vAddr, vWrA, vWrB, vRdA, vRdB;

  int nChk = 0, nBad = 0;
  logic [7:0] rowL = 0, colPrev = 0, colCur = 0;
  logic rowPrev = 0;
  int rowRises = 0, oeCnt = 0, weCnt = 0, wrEvents = 0;
  logic [15:0] expDisp = 0;
  logic [7:0] evRow [16], evCol [16], evWrA [16], evWrB [16];
  logic evBank [16], evWeA [16], evWeB [16];

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] memA(input logic [7:0] r, input logic [7:0] c);
    return 8'(r * 8'd7) + c;
  endfunction
  function automatic logic [7:0] memB(input logic [7:0] r, input logic [7:0] c);
    return r ^ (c + 8'h5A);
  endfunction
  function automatic logic [7:0] expOp(input logic [7:0] o, input logic [7:0] d, input logic [2:0] op);
    if (op == 3'd1) return o ^ d;
    if (op == 3'd2) return o | d;
    if (op == 3'd3) return o & ~d;
    return d;
  endfunction

  assign vRdA = memA(rowL, vAddr);
  assign vRdB = memB(rowL, vAddr);

  vram_arb_top #(.MUX_W(8), .DATA_W(8), .DISP_SLOTS(2), .FREE_WR(2)) dut_i (
    .clk(clk), .rstN(rstN), .modeCompat(modeCompat), .mode16(mode16), .blank(blank),
    .cpuReq(cpuReq), .cpuWe(cpuWe), .cpuAddr(cpuAddr), .cpuWrData(cpuWrData),
    .cpuOp(cpuOp), .cpuPlaneEn(cpuPlaneEn), .cpuWait(cpuWait), .cpuRdData(cpuRdData),
    .vRowStb(vRowStb), .vColStb(vColStb), .vOe(vOe), .vWeA(vWeA), .vWeB(vWeB),
    .vBank(vBank), .vAddr(vAddr), .vWrA(vWrA), .vWrB(vWrB), .vRdA(vRdA), .vRdB(vRdB),
    .pixA(pixA), .pixB(pixB), .pixLoad(pixLoad)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // bus monitor: row latch, strobe counters, write log, display fetch checks
  always @(negedge clk) begin
    if (rstN) begin
      if (vRowStb && !vColStb) rowL <= vAddr;
      if (vColStb) begin colPrev <= colCur; colCur <= vAddr; end
      rowPrev <= vRowStb;
      if (vRowStb && !rowPrev) rowRises <= rowRises + 1;
      if (vOe) oeCnt <= oeCnt + 1;
      if (vWeA || vWeB) weCnt <= weCnt + 1;
      if (vColStb && !vOe) begin
        evRow[wrEvents % 16]  <= rowL;
        evCol[wrEvents % 16]  <= vAddr;
        evWrA[wrEvents % 16]  <= vWrA;
        evWrB[wrEvents % 16]  <= vWrB;
        evBank[wrEvents % 16] <= vBank;
        evWeA[wrEvents % 16]  <= vWeA;
        evWeB[wrEvents % 16]  <= vWeB;
        wrEvents <= wrEvents + 1;
      end
      if (pixLoad) begin
        check(rowL == expDisp[15:8] && colPrev == expDisp[7:0], "R3 display row/col N",
              {16'h0, rowL, colPrev}, {16'h0, expDisp});
        check(colCur == expDisp[7:0] + 8'd1, "R3 second column is N+1", colCur, expDisp[7:0] + 8'd1);
        check(pixA == {memA(rowL, colCur), memA(rowL, colPrev)}, "R4 pixA bytes",
              pixA, {memA(rowL, colCur), memA(rowL, colPrev)});
        check(pixB == {memB(rowL, colCur), memB(rowL, colPrev)}, "R4 pixB bytes",
              pixB, {memB(rowL, colCur), memB(rowL, colPrev)});
        expDisp <= expDisp + 16'd2;
      end
    end
  end

  task automatic doWrite(input logic [15:0] a, input logic [7:0] d, input logic [2:0] op,
                         input logic [3:0] en, input logic m16, output int waits);
    cpuAddr = a; cpuWrData = d; cpuOp = op; cpuPlaneEn = en; mode16 = m16;
    cpuReq = 1; cpuWe = 1; waits = 0;
    #1;
    while (cpuWait && waits < 500) begin @(negedge clk); #2; waits++; end
    @(posedge clk); @(negedge clk); #1;
    cpuReq = 0;
  endtask

  task automatic doRead(input logic [15:0] a, output logic [15:0] data, output logic firstWait,
                        output int waits);
    cpuAddr = a; cpuReq = 1; cpuWe = 0; waits = 0;
    #1;
    firstWait = cpuWait;
    while (cpuWait && waits < 500) begin @(negedge clk); #2; waits++; end
    data = cpuRdData;
    @(posedge clk); @(negedge clk); #1;
    cpuReq = 0;
  endtask

  task automatic waitEvents(input int target);
    int guard = 0;
    while (wrEvents < target && guard < 200) begin @(negedge clk); #1; guard++; end
    check(wrEvents >= target, "R5 write pass reached DRAM", wrEvents, target);
  endtask

  task automatic checkPass(input int idx, input logic [15:0] a, input logic [7:0] d,
                           input logic [2:0] op, input logic [3:0] en, input logic b);
    int i = idx % 16;
    logic [7:0] oA = memA(a[15:8], a[7:0]);
    logic [7:0] oB = memB(a[15:8], a[7:0]);
    check(evRow[i] == a[15:8] && evCol[i] == a[7:0], "R5 write address", {evRow[i], evCol[i]}, a);
    check(evWrA[i] == expOp(oA, d, op), "R5 lane A rmw data", evWrA[i], expOp(oA, d, op));
    check(evWrB[i] == expOp(oB, d, op), "R5 lane B rmw data", evWrB[i], expOp(oB, d, op));
    check(evBank[i] == b, "R6 bank of pass", evBank[i], b);
    check(evWeA[i] == en[b] && evWeB[i] == en[2 + b], "R6 plane strobes",
          {evWeA[i], evWeB[i]}, {en[b], en[2 + b]});
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nChk++; nBad++;
    $display("FAIL watchdog all-requirements actual=timeout expected=finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    int w, base, r0, o0, e0;
    logic [15:0] rd;
    logic fw;
    // R1 reset state
    repeat (4) @(negedge clk);
    #1;
    check(!vRowStb && !vColStb && !vOe && !vWeA && !vWeB && !pixLoad && !cpuWait,
          "R1 outputs quiet in reset", {vRowStb, vColStb, vOe, vWeA, vWeB, pixLoad, cpuWait}, 0);
    rstN = 1;
    begin
      int g = 0;
      @(negedge clk); #1;
      while (!vRowStb && g < 10) begin @(negedge clk); #1; g++; end
      check(vRowStb && vAddr == 8'h00, "R1 first row is 0", {vRowStb, vAddr}, {1'b1, 8'h00});
    end

    // R2 / R11 idle pattern over 20 slots
    r0 = rowRises; o0 = oeCnt; e0 = weCnt;
    repeat (80) @(negedge clk);
    #1;
    check(rowRises - r0 == 20, "R2 one row strobe per slot", rowRises - r0, 20);
    check(oeCnt - o0 == 40, "R11 read timing in every slot", oeCnt - o0, 40);
    check(weCnt == e0, "R11 no write strobe when idle", weCnt - e0, 0);

    // R5 / R6 / R7 vector table
    for (int k = 0; k < NVEC; k++) begin
      logic [15:0] a = VEC[k][31:16];
      logic [7:0]  d = VEC[k][15:8];
      logic [2:0]  op = VEC[k][7:5];
      logic [3:0]  en = VEC[k][4:1];
      logic        m = VEC[k][0];
      base = wrEvents;
      doWrite(a, d, op, en, m, w);
      check(w == 0, "R7 native write into empty buffer", w, 0);
      waitEvents(base + (m ? 2 : 1));
      checkPass(base, a, d, op, en, 1'b0);
      if (m) checkPass(base + 1, a, d, op, en, 1'b1);
      repeat (14) @(negedge clk);
      #1;
      check(wrEvents == base + (m ? 2 : 1), "R6 pass count for mode", wrEvents - base, m ? 2 : 1);
    end

    // R8 buffer occupied
    base = wrEvents;
    doWrite(16'h5566, 8'h11, 3'd0, 4'b0101, 1'b0, w);
    doWrite(16'h6677, 8'h22, 3'd0, 4'b0101, 1'b0, w);
    check(w > 0, "R8 second write waits for buffer", w, 1);
    waitEvents(base + 2);
    checkPass(base, 16'h5566, 8'h11, 3'd0, 4'b0101, 1'b0);
    checkPass(base + 1, 16'h6677, 8'h22, 3'd0, 4'b0101, 1'b0);
    repeat (3) @(negedge clk);

    // R9 compatibility quota
    #1; modeCompat = 1; blank = 0;
    base = wrEvents;
    doWrite(16'h0102, 8'h01, 3'd0, 4'b0001, 1'b0, w);
    waitEvents(base + 1); repeat (2) @(negedge clk); #1;
    doWrite(16'h0103, 8'h02, 3'd0, 4'b0001, 1'b0, w);
    check(w == 0, "R9 second write in period free", w, 0);
    waitEvents(base + 2); repeat (2) @(negedge clk); #1;
    cpuAddr = 16'h0104; cpuWrData = 8'h03; cpuOp = 0; cpuPlaneEn = 4'b0001; mode16 = 0;
    cpuReq = 1; cpuWe = 1;
    #1;
    check(cpuWait == 1'b1, "R9 third write waits", cpuWait, 1);
    repeat (30) @(negedge clk);
    #2;
    check(cpuWait == 1'b1, "R9 still waiting in display period", cpuWait, 1);
    @(negedge clk); #1; blank = 1; #1;
    check(cpuWait == 1'b0, "R9 blanking releases wait", cpuWait, 0);
    @(posedge clk); @(negedge clk); #1; cpuReq = 0;
    waitEvents(base + 3); repeat (2) @(negedge clk); #1;
    blank = 0;
    doWrite(16'h0105, 8'h04, 3'd0, 4'b0001, 1'b0, w);
    check(w == 0, "R9 quota cleared by blanking", w, 0);
    waitEvents(base + 4); repeat (2) @(negedge clk); #1;

    // R7 native mode has no quota
    modeCompat = 0;
    for (int k = 0; k < 3; k++) begin
      base = wrEvents;
      doWrite(16'h0200 + 16'(k), 8'h10, 3'd0, 4'b0001, 1'b0, w);
      check(w == 0, "R7 native display-period write no wait", w, 0);
      waitEvents(base + 1); repeat (2) @(negedge clk); #1;
    end

    // R10 reads
    doRead(16'h3456, rd, fw, w);
    check(fw == 1'b1, "R10 read waits first", fw, 1);
    check(rd == {memB(8'h34, 8'h56), memA(8'h34, 8'h56)}, "R10 read data", rd,
          {memB(8'h34, 8'h56), memA(8'h34, 8'h56)});
    blank = 1;
    doRead(16'hAB10, rd, fw, w);
    check(fw == 1'b1 && w > 0, "R10 read waits in flyback", {fw, 8'(w)}, 9'h101);
    check(rd == {memB(8'hAB, 8'h10), memA(8'hAB, 8'h10)}, "R10 read data flyback", rd,
          {memB(8'hAB, 8'h10), memA(8'hAB, 8'h10)});

    repeat (4) @(negedge clk);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end
endmodule